// File: doc/BRIEF.md
# Controller-Side Queue Port Messaging Unit

This block sits on the device side of a host-to-controller link and presents a small 32-bit register window to the host. Through that window the host takes free request slots from controller memory, posts requests, collects completions, and exchanges non-queued commands through message registers. A doorbell register and two interrupt status and mask pairs carry events in both directions. The same address acts differently for reads and writes. A read of a queue port pops an entry. A write to a queue port pushes one.

The local processor side consumes posted entries from a post queue. Each entry comes with a decoded view: either a controller-memory offset, or a host address rebuilt from its 32-byte-granular form. The local side reports completions into an outbound queue. A completion may swap in a context word for a host-memory request. The local side also answers messages, clears doorbell bits and acknowledges inbound events.

Top module: `qmsg_unit`

## Requirements
- R1: After reset the free list holds DEPTH slot offsets `SLOT_BASE + i*SLOT_STRIDE` for i = 0 to DEPTH-1, oldest first. The post and outbound queues are empty. Both status registers and both masks are zero, and `h_irq` and `l_irq` are low.
- R2: A host read is answered one cycle after the access, with `h_rvalid` high for one cycle. A read of offset 0x40 pops the free list in FIFO order. When the free list is empty it returns 0xFFFFFFFF and pops nothing.
- R3: A host write to 0x40 pushes the written word onto the post queue, and `l_post_valid`/`l_post_entry` show the oldest entry. An accepted write sets inbound status bit 3. A write to a full post queue is dropped. A `l_post_pop` pulse removes the head.
- R4: `l_post_host` equals bit 31 of the head entry. `l_post_addr` is `{entry[26:0], 5'b0}` when bit 31 is set, and otherwise the entry itself.
- R5: A `l_done_push` pulse pushes one word onto the outbound queue and sets outbound status bit 3. The word is `l_done_ctx` when `l_done_entry[31]` and `l_done_ctx_vld` are both high, and `l_done_entry` otherwise. A host read of 0x44 pops this queue in order, and returns 0xFFFFFFFF when the queue is empty.
- R6: A host write to 0x44 with bit 31 clear returns that offset to the tail of the free list. With bit 31 set the write is ignored.
- R7: Host writes to 0x10 and 0x14 store inbound message words. These show on `l_imsg0`/`l_imsg1` and set inbound status bits 0 and 1. A `l_omsg_we` pulse writes outbound message 0 (0x18, `l_omsg_sel`=0) or 1 (0x1C, `l_omsg_sel`=1) and sets outbound status bit 0 or 1. Host writes to 0x18 and 0x1C have no effect.
- R8: A host write to 0x20 ORs its data into the doorbell (`l_doorbell`). If the data is nonzero it also sets inbound status bit 2. Bits that are set in `l_db_clr` are cleared.
- R9: Status is cleared by writing a one to the bit. Host writes to 0x24 and 0x30 clear the bits written as one, and `l_in_clr` clears inbound status bits. A set in the same cycle as a clear wins.
- R10: Masks are written at 0x28 (inbound) and 0x34 (outbound). `h_irq` is high when some outbound status bit is set and its mask bit is clear. `l_irq` follows the same rule for inbound status and mask. Reads of 0x24, 0x28, 0x30 and 0x34 return the registers in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_req | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read data valid |
| h_rdata | output | 32 | Read data |
| h_irq | output | 1 | Host interrupt |
| l_post_valid | output | 1 | Post queue not empty |
| l_post_pop | input | 1 | Remove post queue head |
| l_post_entry | output | 32 | Raw post queue head |
| l_post_host | output | 1 | Head refers to host memory |
| l_post_addr | output | 32 | Decoded head address |
| l_done_push | input | 1 | Push a completion |
| l_done_entry | input | 32 | Completed entry as posted |
| l_done_ctx_vld | input | 1 | Request asks for context output |
| l_done_ctx | input | 32 | Low context word |
| l_omsg_we | input | 1 | Outbound message write |
| l_omsg_sel | input | 1 | Outbound message index |
| l_omsg_data | input | 32 | Outbound message data |
| l_imsg0 | output | 32 | Inbound message 0 |
| l_imsg1 | output | 32 | Inbound message 1 |
| l_doorbell | output | 32 | Inbound doorbell bits |
| l_db_clr | input | 32 | Doorbell bit clear |
| l_in_clr | input | 4 | Inbound status clear |
| l_in_stat | output | 4 | Inbound status |
| l_irq | output | 1 | Local interrupt |

## Verification
Directed cases first drain the reset-seeded free list past empty. They then fill the post queue past full, and mix offset and bit-31 entries so that a wrong decode shifts the address. Completions are issued with every combination of host flag and context flag, which separates substituted words from passed-through entries. A returned free slot is paired with an ignored bit-31 return, and a status set is made to coincide with its clear. A seeded random phase then interleaves pops, posts, returns and completions against bench queue models. This exposes ordering faults, lost pushes at full and wrong empty-read codes.

// File: rtl/qmsg_pkg.sv
package qmsg_pkg;
  localparam int WORD_W = 32;
  localparam int STAT_W = 4;
  typedef logic [WORD_W-1:0] word_t;

  // host-visible byte offsets
  localparam logic [7:0] OFS_IMSG0 = 8'h10;
  localparam logic [7:0] OFS_IMSG1 = 8'h14;
  localparam logic [7:0] OFS_OMSG0 = 8'h18;
  localparam logic [7:0] OFS_OMSG1 = 8'h1C;
  localparam logic [7:0] OFS_DBELL = 8'h20;
  localparam logic [7:0] OFS_ISTAT = 8'h24;
  localparam logic [7:0] OFS_IMASK = 8'h28;
  localparam logic [7:0] OFS_OSTAT = 8'h30;
  localparam logic [7:0] OFS_OMASK = 8'h34;
  localparam logic [7:0] OFS_INQ   = 8'h40;
  localparam logic [7:0] OFS_OUTQ  = 8'h44;

  // status bit positions
  localparam int SB_MSG0 = 0;
  localparam int SB_MSG1 = 1;
  localparam int SB_DB   = 2;
  localparam int SB_Q    = 3;

  localparam word_t EMPTY_CODE = '1;

  function automatic word_t decode_post(word_t e);
    return e[31] ? {e[26:0], 5'b0} : e;
  endfunction

  function automatic word_t done_word(word_t e, logic cv, word_t c);
    return (e[31] && cv) ? c : e;
  endfunction
endpackage

// File: rtl/qmsg_fifo.sv
module qmsg_fifo #(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 32,
  parameter bit INIT_FULL = 1'b0,
  parameter int INIT_BASE = 0,
  parameter int INIT_STEP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             wr_en, rd_en;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_FULL);
  assign head  = mem[rd_ptr];
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = cnt;
    if (wr_en) wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (rd_en) rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    if (wr_en && !rd_en) cnt_nx = cnt + 1'b1;
    else if (rd_en && !wr_en) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= INIT_FULL ? CNT_FULL : '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt    <= cnt_nx;
    end
  end

  generate
    if (INIT_FULL) begin : g_seeded
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(INIT_BASE + i * INIT_STEP);
        end else if (wr_en) begin
          mem[wr_ptr] <= wdata;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wdata;
      end
    end
  endgenerate

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_FULL);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(wr_ptr)));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/qmsg_stat.sv
module qmsg_stat #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_d,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] stat_nx, mask_nx;

  always_comb begin
    stat_nx = (stat & ~clr) | set;
    mask_nx = mask_we ? mask_d : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= stat_nx;
      mask <= mask_nx;
    end
  end

  assign irq = |(stat & ~mask);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((stat & $past(set)) == $past(set)));
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == {W{1'b1}}) |-> !irq);
endmodule

// File: rtl/qmsg_unit.sv
module qmsg_unit
  import qmsg_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 8,
  parameter int SLOT_BASE   = 32'h0000_1000,
  parameter int SLOT_STRIDE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic              h_rvalid,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              l_post_valid,
  input  logic              l_post_pop,
  output logic [31:0]       l_post_entry,
  output logic              l_post_host,
  output logic [31:0]       l_post_addr,
  input  logic              l_done_push,
  input  logic [31:0]       l_done_entry,
  input  logic              l_done_ctx_vld,
  input  logic [31:0]       l_done_ctx,
  input  logic              l_omsg_we,
  input  logic              l_omsg_sel,
  input  logic [31:0]       l_omsg_data,
  output logic [31:0]       l_imsg0,
  output logic [31:0]       l_imsg1,
  output logic [31:0]       l_doorbell,
  input  logic [31:0]       l_db_clr,
  input  logic [3:0]        l_in_clr,
  output logic [3:0]        l_in_stat,
  output logic              l_irq
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  // access decode
  logic acc_wr, acc_rd;
  logic sel_im0, sel_im1, sel_om0, sel_om1, sel_db, sel_ist, sel_imk, sel_ost, sel_omk, sel_iq, sel_oq;
  assign acc_wr  = h_req && h_wr;
  assign acc_rd  = h_req && !h_wr;
  assign sel_im0 = (h_addr == ADDR_W'(OFS_IMSG0));
  assign sel_im1 = (h_addr == ADDR_W'(OFS_IMSG1));
  assign sel_om0 = (h_addr == ADDR_W'(OFS_OMSG0));
  assign sel_om1 = (h_addr == ADDR_W'(OFS_OMSG1));
  assign sel_db  = (h_addr == ADDR_W'(OFS_DBELL));
  assign sel_ist = (h_addr == ADDR_W'(OFS_ISTAT));
  assign sel_imk = (h_addr == ADDR_W'(OFS_IMASK));
  assign sel_ost = (h_addr == ADDR_W'(OFS_OSTAT));
  assign sel_omk = (h_addr == ADDR_W'(OFS_OMASK));
  assign sel_iq  = (h_addr == ADDR_W'(OFS_INQ));
  assign sel_oq  = (h_addr == ADDR_W'(OFS_OUTQ));

  // queues
  word_t free_head, post_head, out_head, out_word;
  logic  free_empty, free_full, post_empty, post_full, out_empty, out_full;
  logic  free_push, free_pop, post_push, out_pop;

  assign free_pop  = acc_rd && sel_iq;
  assign free_push = acc_wr && sel_oq && !h_wdata[31] && !free_full;
  assign post_push = acc_wr && sel_iq;
  assign out_pop   = acc_rd && sel_oq;
  assign out_word  = done_word(l_done_entry, l_done_ctx_vld, l_done_ctx);

  qmsg_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W), .INIT_FULL(1'b1),
              .INIT_BASE(SLOT_BASE), .INIT_STEP(SLOT_STRIDE)) u_free (
    .clk(clk), .rst_n(rst_sn), .push(free_push), .wdata(h_wdata), .pop(free_pop),
    .head(free_head), .empty(free_empty), .full(free_full));

  qmsg_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_post (
    .clk(clk), .rst_n(rst_sn), .push(post_push), .wdata(h_wdata), .pop(l_post_pop),
    .head(post_head), .empty(post_empty), .full(post_full));

  qmsg_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_sn), .push(l_done_push), .wdata(out_word), .pop(out_pop),
    .head(out_head), .empty(out_empty), .full(out_full));

  assign l_post_valid = !post_empty;
  assign l_post_entry = post_head;
  assign l_post_host  = post_head[31];
  assign l_post_addr  = decode_post(post_head);

  // message and doorbell registers
  word_t imsg0, imsg1, omsg0, omsg1, dbell;
  word_t imsg0_nx, imsg1_nx, omsg0_nx, omsg1_nx, dbell_nx;

  always_comb begin
    imsg0_nx = (acc_wr && sel_im0) ? h_wdata : imsg0;
    imsg1_nx = (acc_wr && sel_im1) ? h_wdata : imsg1;
    omsg0_nx = (l_omsg_we && !l_omsg_sel) ? l_omsg_data : omsg0;
    omsg1_nx = (l_omsg_we &&  l_omsg_sel) ? l_omsg_data : omsg1;
    dbell_nx = (dbell & ~l_db_clr) | ((acc_wr && sel_db) ? h_wdata : '0);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      imsg0 <= '0;
      imsg1 <= '0;
      omsg0 <= '0;
      omsg1 <= '0;
      dbell <= '0;
    end else begin
      imsg0 <= imsg0_nx;
      imsg1 <= imsg1_nx;
      omsg0 <= omsg0_nx;
      omsg1 <= omsg1_nx;
      dbell <= dbell_nx;
    end
  end

  assign l_imsg0    = imsg0;
  assign l_imsg1    = imsg1;
  assign l_doorbell = dbell;

  // status and interrupt
  logic [STAT_W-1:0] in_set, in_clr, out_set, out_clr, in_stat, in_mask, out_stat, out_mask;

  always_comb begin
    in_set          = '0;
    in_set[SB_MSG0] = acc_wr && sel_im0;
    in_set[SB_MSG1] = acc_wr && sel_im1;
    in_set[SB_DB]   = acc_wr && sel_db && (|h_wdata);
    in_set[SB_Q]    = post_push && !post_full;
    out_set          = '0;
    out_set[SB_MSG0] = l_omsg_we && !l_omsg_sel;
    out_set[SB_MSG1] = l_omsg_we && l_omsg_sel;
    out_set[SB_Q]    = l_done_push && !out_full;
    in_clr  = l_in_clr | ((acc_wr && sel_ist) ? h_wdata[STAT_W-1:0] : '0);
    out_clr = (acc_wr && sel_ost) ? h_wdata[STAT_W-1:0] : '0;
  end

  qmsg_stat #(.W(STAT_W)) u_in_stat (
    .clk(clk), .rst_n(rst_sn), .set(in_set), .clr(in_clr),
    .mask_we(acc_wr && sel_imk), .mask_d(h_wdata[STAT_W-1:0]),
    .stat(in_stat), .mask(in_mask), .irq(l_irq));

  qmsg_stat #(.W(STAT_W)) u_out_stat (
    .clk(clk), .rst_n(rst_sn), .set(out_set), .clr(out_clr),
    .mask_we(acc_wr && sel_omk), .mask_d(h_wdata[STAT_W-1:0]),
    .stat(out_stat), .mask(out_mask), .irq(h_irq));

  assign l_in_stat = in_stat;

  // read path
  word_t rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_im0) rd_mux = imsg0;
    if (sel_im1) rd_mux = imsg1;
    if (sel_om0) rd_mux = omsg0;
    if (sel_om1) rd_mux = omsg1;
    if (sel_db)  rd_mux = dbell;
    if (sel_ist) rd_mux = WORD_W'(in_stat);
    if (sel_imk) rd_mux = WORD_W'(in_mask);
    if (sel_ost) rd_mux = WORD_W'(out_stat);
    if (sel_omk) rd_mux = WORD_W'(out_mask);
    if (sel_iq)  rd_mux = free_empty ? EMPTY_CODE : free_head;
    if (sel_oq)  rd_mux = out_empty ? EMPTY_CODE : out_head;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= acc_rd;
      if (acc_rd) h_rdata <= rd_mux;
    end
  end

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_rd |=> h_rvalid);
  p_empty_free_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_rd && sel_iq && free_empty) |=> (h_rdata == EMPTY_CODE));
  p_empty_out_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_rd && sel_oq && out_empty) |=> (h_rdata == EMPTY_CODE));
  p_imsg_store_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_wr && sel_im0) |=> (l_imsg0 == $past(h_wdata)));
  p_omsg_ro_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_wr && sel_om0 && !l_omsg_we) |=> $stable(omsg0));
endmodule

// File: tb/test_qmsg_unit.sv
`timescale 1ns/1ps
module test_qmsg_unit;
  localparam int DEPTH = 16;
  localparam int SLOT_BASE = 32'h1000;
  localparam int SLOT_STRIDE = 32'h100;

  logic clk = 1'b0;
  logic rst_n;
  logic h_req, h_wr, h_rvalid, h_irq;
  logic [7:0] h_addr;
  logic [31:0] h_wdata, h_rdata;
  logic l_post_valid, l_post_pop, l_post_host;
  logic [31:0] l_post_entry, l_post_addr;
  logic l_done_push, l_done_ctx_vld, l_omsg_we, l_omsg_sel, l_irq;
  logic [31:0] l_done_entry, l_done_ctx, l_omsg_data, l_imsg0, l_imsg1, l_doorbell, l_db_clr;
  logic [3:0] l_in_clr, l_in_stat;

  qmsg_unit #(.DEPTH(DEPTH), .ADDR_W(8), .SLOT_BASE(SLOT_BASE), .SLOT_STRIDE(SLOT_STRIDE))
    i_qmsg_unit (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mfree[$], mpost[$], mout[$];
  logic [31:0] rd, e, c, w;
  logic cv;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] exp_addr(logic [31:0] x);
    return x[31] ? (x << 5) : x;
  endfunction
  function automatic logic [31:0] exp_word(logic [31:0] x, logic f, logic [31:0] k);
    if (x[31] && f) return k;
    return x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [7:0] a, logic [31:0] d);
    h_req = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_req = 0; h_wr = 0;
  endtask

  task automatic hrd(logic [7:0] a, output logic [31:0] d);
    h_req = 1; h_wr = 0; h_addr = a;
    @(negedge clk);
    h_req = 0;
    d = h_rdata;
    chk("R2 rvalid", {31'b0, h_rvalid}, 32'd1);
  endtask

  task automatic done(logic [31:0] x, logic f, logic [31:0] k);
    l_done_push = 1; l_done_entry = x; l_done_ctx_vld = f; l_done_ctx = k;
    @(negedge clk);
    l_done_push = 0;
  endtask

  task automatic ppop();
    l_post_pop = 1;
    @(negedge clk);
    l_post_pop = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; h_req = 0; h_wr = 0; h_addr = 0; h_wdata = 0;
    l_post_pop = 0; l_done_push = 0; l_done_entry = 0; l_done_ctx_vld = 0; l_done_ctx = 0;
    l_omsg_we = 0; l_omsg_sel = 0; l_omsg_data = 0; l_db_clr = 0; l_in_clr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 h_irq", {31'b0, h_irq}, 0);
    chk("R1 l_irq", {31'b0, l_irq}, 0);
    chk("R1 post empty", {31'b0, l_post_valid}, 0);
    hrd(8'h30, rd); chk("R1 out status", rd, 0);
    hrd(8'h28, rd); chk("R1 in mask", rd, 0);
    hrd(8'h44, rd); chk("R1 out queue empty", rd, 32'hFFFFFFFF);

    // R1/R2 seeded free list drained in order, then empty code
    for (int i = 0; i < DEPTH; i++) begin
      hrd(8'h40, rd); chk("R1 seeded slot", rd, SLOT_BASE + i * SLOT_STRIDE);
    end
    hrd(8'h40, rd); chk("R2 empty free list", rd, 32'hFFFFFFFF);

    // R6 return of offset, host tagged return ignored
    hwr(8'h44, 32'h1500);
    hwr(8'h44, 32'h8000_0001);
    hrd(8'h40, rd); chk("R6 returned slot", rd, 32'h1500);
    hrd(8'h40, rd); chk("R6 tagged return ignored", rd, 32'hFFFFFFFF);
    for (int i = 0; i < DEPTH; i++) begin
      hwr(8'h44, SLOT_BASE + i * SLOT_STRIDE);
      mfree.push_back(SLOT_BASE + i * SLOT_STRIDE);
    end

    // R3/R4 posting and decode
    hwr(8'h40, 32'h1200);
    chk("R3 post valid", {31'b0, l_post_valid}, 1);
    chk("R3 post entry", l_post_entry, 32'h1200);
    chk("R4 offset not host", {31'b0, l_post_host}, 0);
    chk("R4 offset addr", l_post_addr, 32'h1200);
    chk("R3 in status bit3", {28'b0, l_in_stat}, 32'h8);
    chk("R10 l_irq from post", {31'b0, l_irq}, 1);
    hwr(8'h40, 32'h8000_091A);
    ppop();
    chk("R4 host flag", {31'b0, l_post_host}, 1);
    chk("R4 host addr", l_post_addr, 32'h0001_2340);
    ppop();
    chk("R3 empty after pops", {31'b0, l_post_valid}, 0);
    for (int i = 0; i <= DEPTH; i++) hwr(8'h40, 32'h100 + i);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 fill order", l_post_entry, 32'h100 + i);
      ppop();
    end
    chk("R3 overflow dropped", {31'b0, l_post_valid}, 0);
    l_in_clr = 4'hF; @(negedge clk); l_in_clr = 0;
    chk("R9 local clear", {28'b0, l_in_stat}, 0);

    // R5 completions
    done(32'h8000_091A, 1, 32'hCAFE_0001);
    chk("R5 h_irq", {31'b0, h_irq}, 1);
    done(32'h0000_1200, 1, 32'hDEAD_0002);
    done(32'h8000_0777, 0, 32'hDEAD_0003);
    hrd(8'h30, rd); chk("R5 out status bit3", rd, 32'h8);
    hrd(8'h44, rd); chk("R5 ctx substituted", rd, 32'hCAFE_0001);
    hrd(8'h44, rd); chk("R5 offset not substituted", rd, 32'h1200);
    hrd(8'h44, rd); chk("R5 no ctx flag", rd, 32'h8000_0777);
    hrd(8'h44, rd); chk("R5 empty out queue", rd, 32'hFFFFFFFF);
    hwr(8'h30, 32'h8);
    chk("R9 host W1C", {31'b0, h_irq}, 0);

    // R7 messages
    hwr(8'h10, 32'hA5A5_0001);
    chk("R7 imsg0", l_imsg0, 32'hA5A5_0001);
    hwr(8'h14, 32'h5A5A_0002);
    chk("R7 imsg1", l_imsg1, 32'h5A5A_0002);
    chk("R7 in status", {28'b0, l_in_stat}, 32'h3);
    l_omsg_we = 1; l_omsg_sel = 0; l_omsg_data = 32'hA5A5_0001;
    @(negedge clk);
    l_omsg_sel = 1; l_omsg_data = 32'h7777_0000;
    @(negedge clk);
    l_omsg_we = 0;
    hrd(8'h18, rd); chk("R7 omsg0 echoes command", rd, 32'hA5A5_0001);
    hwr(8'h18, 32'h0BAD_0BAD);
    hwr(8'h1C, 32'h0BAD_0BAD);
    hrd(8'h18, rd); chk("R7 omsg0 host write ignored", rd, 32'hA5A5_0001);
    hrd(8'h1C, rd); chk("R7 omsg1", rd, 32'h7777_0000);
    hrd(8'h30, rd); chk("R7 out status", rd, 32'h3);

    // R8 doorbell
    hwr(8'h24, 32'hF);
    hwr(8'h20, 32'h5);
    hwr(8'h20, 32'h30);
    chk("R8 doorbell OR", l_doorbell, 32'h35);
    chk("R8 status bit2", {28'b0, l_in_stat}, 32'h4);
    l_db_clr = 32'h1; @(negedge clk); l_db_clr = 0;
    chk("R8 local clear", l_doorbell, 32'h34);
    hwr(8'h24, 32'h4);
    hwr(8'h20, 32'h0);
    chk("R8 zero write no status", {28'b0, l_in_stat}, 0);

    // R9 set wins over clear in same cycle
    hwr(8'h30, 32'hF);
    l_done_push = 1; l_done_entry = 32'h2200; l_done_ctx_vld = 0;
    h_req = 1; h_wr = 1; h_addr = 8'h30; h_wdata = 32'h8;
    @(negedge clk);
    l_done_push = 0; h_req = 0; h_wr = 0;
    hrd(8'h30, rd); chk("R9 set wins", rd, 32'h8);

    // R10 masking
    hwr(8'h34, 32'h8);
    chk("R10 masked h_irq", {31'b0, h_irq}, 0);
    hrd(8'h34, rd); chk("R10 mask readback", rd, 32'h8);
    hwr(8'h34, 32'h0);
    chk("R10 unmasked h_irq", {31'b0, h_irq}, 1);
    hwr(8'h10, 32'h1);
    hwr(8'h28, 32'hE);
    chk("R10 l_irq bit0 unmasked", {31'b0, l_irq}, 1);
    hwr(8'h28, 32'hF);
    chk("R10 l_irq masked", {31'b0, l_irq}, 0);
    hrd(8'h44, rd); chk("R5 pending word", rd, 32'h2200);
    hwr(8'h30, 32'hF); hwr(8'h24, 32'hF); hwr(8'h28, 32'h0);

    // random phase against queue models
    for (int k = 0; k < 600; k++) begin
      case ($urandom_range(0, 5))
        0: begin
          hrd(8'h40, rd);
          if (mfree.size() == 0) chk("R2 rand empty free", rd, 32'hFFFFFFFF);
          else chk("R2 rand free pop", rd, mfree.pop_front());
        end
        1: begin
          w = $urandom() & 32'h8000_FFFF;
          hwr(8'h44, w);
          if (!w[31] && mfree.size() < DEPTH) mfree.push_back(w);
        end
        2: begin
          w = $urandom();
          hwr(8'h40, w);
          if (mpost.size() < DEPTH) mpost.push_back(w);
        end
        3: begin
          chk("R3 rand post valid", {31'b0, l_post_valid}, {31'b0, mpost.size() != 0});
          if (mpost.size() != 0) begin
            chk("R3 rand post head", l_post_entry, mpost[0]);
            chk("R4 rand decode", l_post_addr, exp_addr(mpost[0]));
            void'(mpost.pop_front());
            ppop();
          end
        end
        4: begin
          e = $urandom(); cv = 1'($urandom_range(0, 1)); c = $urandom();
          done(e, cv, c);
          if (mout.size() < DEPTH) mout.push_back(exp_word(e, cv, c));
        end
        default: begin
          hrd(8'h44, rd);
          if (mout.size() == 0) chk("R5 rand empty out", rd, 32'hFFFFFFFF);
          else chk("R5 rand out pop", rd, mout.pop_front());
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule